// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Load Controller

This block is a clocked model of the write side of a byte-wide parallel EEPROM. It watches three active-low strobes: chip enable, write enable and output enable. It also takes a 17-bit address and an 8-bit data bus. Each valid byte load goes into a 256-entry page buffer. Once the host stops loading, the buffered page is written to a behavioural storage array and the block stays busy for a programming interval.

The strobes pass through a two-flop synchronizer, and all edges are detected in the clock domain. A load is active while chip enable and write enable are both low and output enable is high. The address is taken when this condition begins, which is the later of the two falling strobes. The data is taken when the condition ends, which is the earlier of the two rising strobes. Loading may go on for as long as the host keeps each gap inside the byte-load window. When that window runs out, the block commits every buffered byte to the array in ascending offset order. It then waits out the programming time and releases busy.

Both the byte-load window and the programming time are parameters in clock cycles. `WIN_CYCLES` defaults to 100 µs and `PROG_CYCLES` to 5 ms, both at 125 MHz.

Top module: `eeprom_page_loader`

## Requirements
- R1: A byte load is accepted only while the synchronized strobes show chip enable low, write enable low and output enable high. A strobe pattern with output enable low, or with chip enable high, loads nothing and starts no programming.
- R2: The load address is sampled when the active condition begins, that is, at the later of the chip-enable and write-enable falling edges. An address present only before that edge has no effect.
- R3: The load data is the value on the data bus just before the active condition ends, that is, at the earlier of the two rising edges. Data changed after that edge has no effect.
- R4: Address bits 16:8 form the page number and bits 7:0 the byte offset, so a page holds 256 bytes. Two loads to the same offset in one operation keep the later data.
- R5: During an operation, a load whose page number differs from the first load's page is discarded. It writes nothing and does not restart the byte-load window.
- R6: Programming begins once `WIN_CYCLES` clock cycles have passed since the start of the latest accepted load, provided no accepted load is still in progress. Every accepted load restarts the window, and the number of loads is unlimited.
- R7: When programming begins, busy rises. Each buffered offset is then written exactly once to the array at {page, offset}, with the latest data for that offset. Busy stays high for exactly 256 + `PROG_CYCLES` cycles.
- R8: While busy is high, write strobes are ignored. They add nothing to the array, and they do not start a new operation after busy falls.
- R9: The array write strobe `mem_we` is only ever asserted while busy is high.
- R10: After reset, busy and `mem_we` are low and the page buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | 17 | Byte address; 16:8 page, 7:0 offset |
| din | input | 8 | Write data |
| busy | output | 1 | Programming in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 17 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Some internal faults show up at the ports as the wrong number of array writes, or as writes to the wrong page or with the wrong data. Among them are a mis-tracked page number, a stale offset or data latch, and a load-in-progress flag that is not cleared. These faults become visible during the commit burst that follows the window expiry. A window counter that is wrongly restarted moves the rising edge of busy by tens of cycles, and the bench watches for this in bounded polling windows. A buffer that is never cleared produces extra writes in the next operation.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  localparam int ADDR_W     = 17;
  localparam int DATA_W     = 8;
  localparam int OFF_W      = 8;
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int STB_W      = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_PROG   = 2'd3
  } ld_state_e;
endpackage

// File: rtl/eepw_strobe_sync.sv
module eepw_strobe_sync
  import eepw_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STB_W-1:0] raw_n,    // {oe_n, we_n, ce_n}
  output logic             act,
  output logic             act_rise,
  output logic             act_fall
);
  logic [STB_W-1:0] pipe [STAGES];
  logic             act_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '1;
          else        pipe[0] <= raw_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '1;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  // active: ce low, we low, oe high
  assign act = !pipe[STAGES-1][0] && !pipe[STAGES-1][1] && pipe[STAGES-1][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign act_rise = act && !act_q;
  assign act_fall = !act && act_q;
endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf
  import eepw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              clr_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0]     store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_off] <= wr_data;
  end

  genvar e;
  generate
    for (e = 0; e < PAGE_BYTES; e++) begin : g_valid
      logic set_e, clr_e;
      assign set_e = wr_en && (wr_off == OFF_W'(e));
      assign clr_e = clr_en && (rd_off == OFF_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     valid_q[e] <= 1'b0;
        else if (set_e) valid_q[e] <= 1'b1;
        else if (clr_e) valid_q[e] <= 1'b0;
      end
    end
  endgenerate

  assign rd_valid = valid_q[rd_off];
  assign rd_data  = store[rd_off];

  AST_NO_LOAD_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en)); // R8
endmodule

// File: rtl/eepw_load_ctrl.sv
module eepw_load_ctrl
  import eepw_pkg::*;
#(
  parameter int WIN_CYCLES  = 12500,
  parameter int PROG_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              act_rise,
  input  logic              act_fall,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              buf_we,
  output logic [OFF_W-1:0]  buf_wr_off,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic [OFF_W-1:0]  scan_off,
  output logic              buf_clr,
  input  logic              buf_rd_valid,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int WIN_W  = (WIN_CYCLES  > 1) ? $clog2(WIN_CYCLES)  : 1;
  localparam int PROG_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_CYCLES - 1);
  localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYCLES - 1);
  localparam logic [OFF_W-1:0]  OFF_LAST  = OFF_W'(PAGE_BYTES - 1);

  ld_state_e         st_q, st_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              pend_q, pend_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [OFF_W-1:0]  scan_q, scan_d;
  logic [PROG_W-1:0] prg_q, prg_d;

  logic [PAGE_W-1:0] page_in;
  logic              accept;

  assign page_in = addr[ADDR_W-1:OFF_W];
  assign accept  = act_rise &&
                   ((st_q == ST_IDLE) || ((st_q == ST_LOAD) && (page_in == page_q)));

  // next-state logic
  always_comb begin
    st_d    = st_q;
    page_d  = page_q;
    off_d   = off_q;
    dat_d   = dat_q;
    pend_d  = pend_q;
    win_d   = win_q;
    scan_d  = scan_q;
    prg_d   = prg_q;
    buf_we  = 1'b0;
    buf_clr = 1'b0;
    mem_we  = 1'b0;

    if (accept) begin
      pend_d = 1'b1;
      off_d  = addr[OFF_W-1:0];
      dat_d  = din;
      win_d  = '0;
      st_d   = ST_LOAD;
      if (st_q == ST_IDLE) page_d = page_in;
    end else if (pend_q && act) begin
      dat_d = din;
    end

    if (pend_q && act_fall) begin
      buf_we = 1'b1;
      pend_d = 1'b0;
    end

    unique case (st_q)
      ST_IDLE: ;
      ST_LOAD: begin
        if (!accept) begin
          if (win_q != WIN_LAST) begin
            win_d = win_q + 1'b1;
          end else if (!pend_q) begin
            st_d   = ST_COMMIT;
            scan_d = '0;
          end
        end
      end
      ST_COMMIT: begin
        mem_we  = buf_rd_valid;
        buf_clr = 1'b1;
        scan_d  = scan_q + 1'b1;
        if (scan_q == OFF_LAST) begin
          st_d  = ST_PROG;
          prg_d = '0;
        end
      end
      ST_PROG: begin
        if (prg_q == PROG_LAST) st_d  = ST_IDLE;
        else                    prg_d = prg_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
      off_q  <= '0;
      dat_q  <= '0;
      pend_q <= 1'b0;
      win_q  <= '0;
      scan_q <= '0;
      prg_q  <= '0;
    end else begin
      st_q   <= st_d;
      page_q <= page_d;
      off_q  <= off_d;
      dat_q  <= dat_d;
      pend_q <= pend_d;
      win_q  <= win_d;
      scan_q <= scan_d;
      prg_q  <= prg_d;
    end
  end

  assign busy        = (st_q == ST_COMMIT) || (st_q == ST_PROG);
  assign buf_wr_off  = off_q;
  assign buf_wr_data = dat_q;
  assign scan_off    = scan_q;
  assign mem_addr    = {page_q, scan_q};
  assign mem_wdata   = buf_rd_data;

  AST_NO_STORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy); // R8
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD && $past(st_q) == ST_LOAD) |-> $stable(page_q)); // R5
  AST_WINDOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COMMIT && $past(st_q) == ST_LOAD) |-> ($past(win_q) == WIN_LAST && !$past(pend_q))); // R6
  AST_BUSY_ENDS_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(prg_q) == PROG_LAST); // R7
endmodule

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader
  import eepw_pkg::*;
#(
  parameter int WIN_CYCLES  = 12500,
  parameter int PROG_CYCLES = 625000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              act, act_rise, act_fall;
  logic              buf_we, buf_clr, buf_rd_valid;
  logic [OFF_W-1:0]  buf_wr_off, scan_off;
  logic [DATA_W-1:0] buf_wr_data, buf_rd_data;

  eepw_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_n    ({oe_n, we_n, ce_n}),
    .act      (act),
    .act_rise (act_rise),
    .act_fall (act_fall)
  );

  eepw_load_ctrl #(.WIN_CYCLES(WIN_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .act          (act),
    .act_rise     (act_rise),
    .act_fall     (act_fall),
    .addr         (addr),
    .din          (din),
    .busy         (busy),
    .buf_we       (buf_we),
    .buf_wr_off   (buf_wr_off),
    .buf_wr_data  (buf_wr_data),
    .scan_off     (scan_off),
    .buf_clr      (buf_clr),
    .buf_rd_valid (buf_rd_valid),
    .buf_rd_data  (buf_rd_data),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata)
  );

  eepw_page_buf u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (buf_we),
    .wr_off   (buf_wr_off),
    .wr_data  (buf_wr_data),
    .rd_off   (scan_off),
    .clr_en   (buf_clr),
    .rd_valid (buf_rd_valid),
    .rd_data  (buf_rd_data)
  );

  AST_ARRAY_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R9
endmodule

// File: tb/tb_eeprom_page_loader.sv
module tb_eeprom_page_loader;
  localparam int WIN  = 64;
  localparam int PROG = 40;
  localparam int PAGE = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, we_n, oe_n;
  logic [16:0] addr;
  logic [7:0]  din;
  logic        busy, mem_we;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int busy_len = 0;
  int got_cnt = 0;
  bit done = 0;

  logic [7:0] exp_d [PAGE];
  bit         exp_v [PAGE];
  logic [7:0] got_d [PAGE];
  bit         got_v [PAGE];
  logic [8:0] exp_page;

  always #4 clk = ~clk;  // 125 MHz

  eeprom_page_loader #(.WIN_CYCLES(WIN), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v_i);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v_i);
    end
  endtask

  // array write monitor
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      check(busy, "R9 write outside busy", 0, 1);
      check(mem_addr[16:8] == exp_page, "R7 write page", int'(mem_addr[16:8]), int'(exp_page));
      check(!got_v[mem_addr[7:0]], "R7 offset written twice", int'(mem_addr[7:0]), -1);
      got_v[mem_addr[7:0]] = 1'b1;
      got_d[mem_addr[7:0]] = mem_wdata;
      got_cnt++;
    end
    if (rst_n && busy) busy_len++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int exp_count();
    int n = 0;
    for (int i = 0; i < PAGE; i++) if (exp_v[i]) n++;
    return n;
  endfunction

  task automatic new_op(input logic [8:0] pg);
    exp_page = pg;
    for (int i = 0; i < PAGE; i++) begin
      exp_v[i] = 0; got_v[i] = 0; exp_d[i] = 0; got_d[i] = 0;
    end
    got_cnt = 0;
    busy_len = 0;
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // mode 0: write-enable controlled, mode 1: chip-enable controlled.
  // a0/d0 present at first fall; a1 present at second fall; d1 after first rise.
  task automatic load_ex(input logic [16:0] a0, input logic [16:0] a1,
                         input logic [7:0] d0, input logic [7:0] d1, input bit mode);
    @(negedge clk);
    oe_n = 1'b1; addr = a0; din = d0;
    if (mode) we_n = 1'b0; else ce_n = 1'b0;
    waitc(3);
    addr = a1;
    waitc(1);
    if (mode) ce_n = 1'b0; else we_n = 1'b0;
    waitc(4);
    if (mode) ce_n = 1'b1; else we_n = 1'b1;
    waitc(4);
    din = d1;
    waitc(2);
    ce_n = 1'b1; we_n = 1'b1;
    waitc(2);
  endtask

  task automatic load(input logic [16:0] a, input logic [7:0] d, input bit mode);
    load_ex(a, a, d, d, mode);
  endtask

  task automatic put(input logic [16:0] a, input logic [7:0] d, input bit mode);
    load(a, d, mode);
    exp_v[a[7:0]] = 1'b1;
    exp_d[a[7:0]] = d;
  endtask

  task automatic wait_rise(input int limit, input string req);
    int n = 0;
    while (!busy && n < limit) begin @(negedge clk); n++; end
    check(busy, req, n, limit);
  endtask

  task automatic wait_fall();
    int n = 0;
    while (busy && n < PAGE + PROG + 50) begin @(negedge clk); n++; end
  endtask

  task automatic compare(input string req);
    int bad = 0;
    for (int i = 0; i < PAGE; i++)
      if (exp_v[i] != got_v[i] || (exp_v[i] && exp_d[i] != got_d[i])) bad++;
    check(bad == 0, req, bad, 0);
    check(got_cnt == exp_count(), "R7 write count", got_cnt, exp_count());
  endtask

  task automatic finish_op(input string req);
    wait_rise(WIN + 40, "R6 programming start");
    wait_fall();
    check(busy_len == PAGE + PROG, "R7 busy length", busy_len, PAGE + PROG);
    compare(req);
  endtask

  task automatic expect_idle(input int n, input string req);
    int hi = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (busy) hi++; end
    check(hi == 0 && got_cnt == 0, req, hi + got_cnt, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    exp_page = '0;
    new_op(9'd0);
    waitc(5);
    check(busy == 1'b0, "R10 busy at reset", busy, 0);
    check(mem_we == 1'b0, "R10 mem_we at reset", mem_we, 0);
    @(negedge clk); rst_n = 1'b1;
    waitc(3);

    // R10: buffer empty -> first op writes only what it loads
    new_op(9'd3);
    put({9'd3, 8'd10}, 8'hA5, 0);
    put({9'd3, 8'd0},  8'h01, 1);
    put({9'd3, 8'd255}, 8'hFF, 0);
    finish_op("R4 R10 basic page");

    // R4: duplicate offset keeps later data
    new_op(9'd77);
    put({9'd77, 8'd5}, 8'h11, 0);
    put({9'd77, 8'd5}, 8'h22, 1);
    finish_op("R4 duplicate offset");

    // R1: output enable low, chip enable high
    new_op(9'd0);
    @(negedge clk); addr = 17'h00123; din = 8'h5A; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    waitc(6); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    waitc(2); we_n = 1'b0; waitc(6); we_n = 1'b1;
    expect_idle(WIN + 40, "R1 no load without enables");

    // R2: address from later falling edge, both modes
    new_op(9'd20);
    load_ex({9'd99, 8'd1}, {9'd20, 8'd7}, 8'h3C, 8'h3C, 0);
    exp_v[7] = 1; exp_d[7] = 8'h3C;
    load_ex({9'd98, 8'd2}, {9'd20, 8'd8}, 8'hC3, 8'hC3, 1);
    exp_v[8] = 1; exp_d[8] = 8'hC3;
    finish_op("R2 late address edge");

    // R3: data from first rising edge, both modes
    new_op(9'd21);
    load_ex({9'd21, 8'd40}, {9'd21, 8'd40}, 8'h12, 8'hEE, 0);
    exp_v[40] = 1; exp_d[40] = 8'h12;
    load_ex({9'd21, 8'd41}, {9'd21, 8'd41}, 8'h34, 8'hDD, 1);
    exp_v[41] = 1; exp_d[41] = 8'h34;
    finish_op("R3 early data edge");

    // R5: mismatched page ignored and window not restarted
    new_op(9'd50);
    put({9'd50, 8'd9}, 8'h99, 0);
    waitc(2);
    load({9'd51, 8'd6}, 8'h66, 0);
    wait_rise(46, "R5 window not restarted by foreign page");
    wait_fall();
    compare("R5 foreign page discarded");

    // R6: long gaps inside the window keep loading alive
    new_op(9'd300);
    for (int k = 0; k < 4; k++) begin
      put({9'd300, 8'(k * 3)}, 8'(8'h40 + k), 1'(k));
      waitc(40);
      check(!busy, "R6 window restarted by each load", busy, 0);
    end
    finish_op("R6 long loading");

    // R8: strobes during busy ignored
    new_op(9'd123);
    put({9'd123, 8'd1}, 8'hAB, 0);
    wait_rise(WIN + 40, "R8 programming start");
    load({9'd123, 8'd2}, 8'hCD, 0);
    wait_fall();
    compare("R8 load during busy ignored");
    new_op(9'd123);
    expect_idle(WIN + 40, "R8 no operation after busy");

    // constrained random operations
    for (int op = 0; op < 5; op++) begin
      logic [8:0] pg;
      int n;
      pg = 9'($urandom);
      new_op(pg);
      n = 1 + ($urandom % 24);
      for (int j = 0; j < n; j++)
        put({pg, 8'($urandom % 32)}, 8'($urandom), 1'($urandom));
      finish_op("R4 R7 random page");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule